// File: doc/BRIEF.md
# Command Ring Pointer Engine

This block sits on the controller side of a codec link and drains a circular ring of 32-bit outgoing command words held in memory. Software owns the write pointer: it places a command in the slot after the current write pointer and then moves the pointer onto that slot. The engine owns the read pointer. While the run bit is set and the two pointers differ, the engine steps to the next slot, reads that slot through a simple memory read port, and offers the command on a valid/ready transmit port. The four-bit codec address is taken from the top of the word and sent alongside. The read pointer moves only once the transmit side has accepted the command.

The read pointer is cleared through a two-step handshake. Software sets a reset bit, sees it reflected, then clears it and sees the pointer read as zero. A size register selects a ring of 2, 16 or 256 entries, and all pointer arithmetic wraps at that size. Full and empty flags are compared from the two pointers. Clearing the run bit stops new fetches, but the bit still reads as set until the command in flight has been accepted. While the controller is in a low-power state, the write pointer reads back as all ones, so software can tell that the controller is unreachable.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the write pointer, read pointer and run bit read 0, the size code reads 2 and `tx_valid` is low. Register selector codes are: 0 write pointer (bits 7:0), 1 read pointer (bits 7:0, reset bit 15), 2 control (run in bit 0), 3 size code (bits 1:0).
- R2: Size code 0 gives 2 entries, code 1 gives 16, and codes 2 and 3 give 256. The next slot is (pointer + 1) modulo the size, and a write-pointer write keeps only the bits that are below the size.
- R3: Writing the read-pointer register with bit 15 set makes bit 15 read back as 1 from the next cycle on, clears the pointer to 0 and blocks all fetching. A later write with bit 15 clear makes the register read 0. Writes with bit 15 clear never load the pointer.
- R4: While running, with the reset bit clear and the pointers unequal, the engine reads slot (read pointer + 1) mod size and presents its word on the transmit port. Commands go out in ring order, and the read pointer takes the slot number only in the cycle the transmit handshake completes.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_cmd` holds its value. `tx_codec` always equals bits 31:28 of `tx_cmd`.
- R6: Clearing the run bit starts no new fetch. The run bit reads 1 until a command in flight has been accepted, then reads 0.
- R7: `ring_full` is high when (write pointer + 1) mod size equals the read pointer. `ring_empty` is high when the two pointers are equal.
- R8: While `low_power` is high, a read of the write-pointer register returns 0xFFFF and the other registers read normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_power | input | 1 | Controller is in a low-power state |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register selected for the write |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_sel | input | 2 | Register selected for the read |
| reg_rd_data | output | 16 | Register read data (combinational) |
| mem_rd_en | output | 1 | Memory read request, held until data returns |
| mem_rd_addr | output | 8 | Ring slot being read |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | 32 | Memory read data |
| tx_valid | output | 1 | Command offered to the link |
| tx_ready | input | 1 | Link accepts the command |
| tx_cmd | output | 32 | Command word |
| tx_codec | output | 4 | Target codec address |
| ring_full | output | 1 | Ring is full |
| ring_empty | output | 1 | Ring is empty |

## Verification
The hardest situation to reach from the ports is a stop request that arrives while a fetched command is still waiting on the link. In that window the run bit must still read as set, and no later fetch may follow. The bench reaches it by holding `tx_ready` low until a command is offered, clearing the run bit in that window and reading control back, and only then releasing the link. A second awkward case is the wrap from the last slot to slot 0. The bench reaches it cheaply by switching to the 16-entry ring after a read-pointer reset and draining fifteen commands before adding more.

// File: rtl/cring_pkg.sv
package cring_pkg;

   typedef enum logic [1:0] {
      SEL_WPTR = 2'd0,
      SEL_RPTR = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_SIZE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_FETCH = 2'd1,
      ENG_SEND  = 2'd2
   } eng_state_e;

   // size code to slot mask: 0 -> 2 slots, 1 -> 16 slots, else 256 slots
   function automatic logic [7:0] ring_mask8(input logic [1:0] code);
      case (code)
         2'd0:    ring_mask8 = 8'h01;
         2'd1:    ring_mask8 = 8'h0F;
         default: ring_mask8 = 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/cring_regs.sv
module cring_regs
   import cring_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             low_power,
   input  logic             wr_en,
   input  reg_sel_e         wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  reg_sel_e         rd_sel,
   output logic [REG_W-1:0] rd_data,
   input  logic [PTR_W-1:0] rptr,
   input  logic             busy,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] mask,
   output logic             run_req,
   output logic             rp_rst
);

   localparam int RST_BIT = REG_W - 1;
   localparam logic [1:0] SIZE_RST = 2'd2;

   logic [1:0] size_code;

   assign mask = PTR_W'(ring_mask8(size_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr      <= '0;
         run_req   <= 1'b0;
         rp_rst    <= 1'b0;
         size_code <= SIZE_RST;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_WPTR: wptr      <= wr_data[PTR_W-1:0] & mask;
            SEL_RPTR: rp_rst    <= wr_data[RST_BIT];
            SEL_CTRL: run_req   <= wr_data[0];
            SEL_SIZE: size_code <= wr_data[1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_WPTR: begin
            if (low_power) rd_data = '1;
            else           rd_data[PTR_W-1:0] = wptr;
         end
         SEL_RPTR: begin
            rd_data[PTR_W-1:0] = rptr;
            rd_data[RST_BIT]   = rp_rst;
         end
         SEL_CTRL: rd_data[0]   = run_req | busy;
         SEL_SIZE: rd_data[1:0] = size_code;
         default:  rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cring_fetch.sv
module cring_fetch
   import cring_pkg::*;
#(
   parameter int PTR_W = 8,
   parameter int CMD_W = 32,
   parameter int CAD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic             rp_rst,
   input  logic [PTR_W-1:0] wptr,
   input  logic [PTR_W-1:0] mask,
   output logic [PTR_W-1:0] rptr,
   output logic             busy,
   output logic             mem_rd_en,
   output logic [PTR_W-1:0] mem_rd_addr,
   input  logic             mem_rd_valid,
   input  logic [CMD_W-1:0] mem_rd_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [CMD_W-1:0] tx_cmd,
   output logic [CAD_W-1:0] tx_codec
);

   eng_state_e       state;
   logic [PTR_W-1:0] rptr_q;
   logic [PTR_W-1:0] slot_q;
   logic [CMD_W-1:0] cmd_q;
   logic             pending;

   assign pending = (wptr & mask) != (rptr_q & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ENG_IDLE;
         rptr_q <= '0;
         slot_q <= '0;
         cmd_q  <= '0;
      end else if (rp_rst) begin
         state  <= ENG_IDLE;
         rptr_q <= '0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (run_req && pending) begin
                  slot_q <= (rptr_q + PTR_W'(1)) & mask;
                  state  <= ENG_FETCH;
               end
            end
            ENG_FETCH: begin
               if (mem_rd_valid) begin
                  cmd_q <= mem_rd_data;
                  state <= ENG_SEND;
               end
            end
            ENG_SEND: begin
               if (tx_ready) begin
                  rptr_q <= slot_q;
                  state  <= ENG_IDLE;
               end
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   assign rptr        = rptr_q;
   assign busy        = (state != ENG_IDLE);
   assign mem_rd_en   = (state == ENG_FETCH);
   assign mem_rd_addr = slot_q;
   assign tx_valid    = (state == ENG_SEND);
   assign tx_cmd      = cmd_q;
   assign tx_codec    = cmd_q[CMD_W-1 -: CAD_W];

endmodule

// File: rtl/cring_status.sv
module cring_status #(
   parameter int PTR_W = 8
) (
   input  logic [PTR_W-1:0] wptr,
   input  logic [PTR_W-1:0] rptr,
   input  logic [PTR_W-1:0] mask,
   output logic             full,
   output logic             empty
);

   logic [PTR_W-1:0] wp_next;

   assign wp_next = (wptr + PTR_W'(1)) & mask;
   assign full    = (wp_next == (rptr & mask));
   assign empty   = ((wptr & mask) == (rptr & mask));

endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
   import cring_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int PTR_W = 8,
   parameter int CMD_W = 32,
   parameter int CAD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             low_power,
   input  logic             reg_wr_en,
   input  logic [1:0]       reg_wr_sel,
   input  logic [REG_W-1:0] reg_wr_data,
   input  logic [1:0]       reg_rd_sel,
   output logic [REG_W-1:0] reg_rd_data,
   output logic             mem_rd_en,
   output logic [PTR_W-1:0] mem_rd_addr,
   input  logic             mem_rd_valid,
   input  logic [CMD_W-1:0] mem_rd_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [CMD_W-1:0] tx_cmd,
   output logic [CAD_W-1:0] tx_codec,
   output logic             ring_full,
   output logic             ring_empty
);

   generate
      if (PTR_W < 8) begin : g_bad_ptr
         $error("PTR_W must cover a 256-slot ring");
      end
      if (REG_W <= PTR_W) begin : g_bad_reg
         $error("REG_W must leave room for the reset bit");
      end
      if (CAD_W > CMD_W) begin : g_bad_cad
         $error("codec field wider than the command");
      end
   endgenerate

   logic [PTR_W-1:0] wptr;
   logic [PTR_W-1:0] rptr;
   logic [PTR_W-1:0] mask;
   logic             run_req;
   logic             rp_rst;
   logic             busy;

   cring_regs #(.REG_W(REG_W), .PTR_W(PTR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .low_power (low_power),
      .wr_en     (reg_wr_en),
      .wr_sel    (reg_sel_e'(reg_wr_sel)),
      .wr_data   (reg_wr_data),
      .rd_sel    (reg_sel_e'(reg_rd_sel)),
      .rd_data   (reg_rd_data),
      .rptr      (rptr),
      .busy      (busy),
      .wptr      (wptr),
      .mask      (mask),
      .run_req   (run_req),
      .rp_rst    (rp_rst)
   );

   cring_fetch #(.PTR_W(PTR_W), .CMD_W(CMD_W), .CAD_W(CAD_W)) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_req      (run_req),
      .rp_rst       (rp_rst),
      .wptr         (wptr),
      .mask         (mask),
      .rptr         (rptr),
      .busy         (busy),
      .mem_rd_en    (mem_rd_en),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_data  (mem_rd_data),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .tx_cmd       (tx_cmd),
      .tx_codec     (tx_codec)
   );

   cring_status #(.PTR_W(PTR_W)) u_status (
      .wptr  (wptr),
      .rptr  (rptr),
      .mask  (mask),
      .full  (ring_full),
      .empty (ring_empty)
   );

endmodule

// File: rtl/cring_chk.sv
module cring_chk #(
   parameter int PTR_W = 8,
   parameter int CMD_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [CMD_W-1:0] tx_cmd,
   input logic [PTR_W-1:0] rptr,
   input logic             rp_rst,
   input logic             mem_rd_en,
   input logic             run_req,
   input logic             busy,
   input logic             ring_full,
   input logic             ring_empty
);

   // R5
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !rp_rst) |=> (tx_valid && $stable(tx_cmd)));

   // R4
   rptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rptr) |-> ($past(tx_valid && tx_ready) || $past(rp_rst)));

   // R3
   fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_en) |-> $past(run_req && !rp_rst));

   // R6
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_req && !busy) |=> !mem_rd_en);

   // R7
   full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_full |-> !ring_empty);

endmodule

bind cmd_ring_engine cring_chk #(.PTR_W(PTR_W), .CMD_W(CMD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_cmd     (tx_cmd),
   .rptr       (rptr),
   .rp_rst     (rp_rst),
   .mem_rd_en  (mem_rd_en),
   .run_req    (run_req),
   .busy       (busy),
   .ring_full  (ring_full),
   .ring_empty (ring_empty)
);

// File: tb/sim_cmd_ring_engine.sv
`timescale 1ns/1ps
module sim_cmd_ring_engine;

   localparam logic [1:0] S_WP = 2'd0, S_RP = 2'd1, S_CT = 2'd2, S_SZ = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        low_power = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_wr_sel = 2'd0;
   logic [15:0] reg_wr_data = '0;
   logic [1:0]  reg_rd_sel = 2'd0;
   logic [15:0] reg_rd_data;
   logic        mem_rd_en;
   logic [7:0]  mem_rd_addr;
   logic        mem_rd_valid;
   logic [31:0] mem_rd_data;
   logic        tx_valid;
   logic        tx_ready = 1'b1;
   logic [31:0] tx_cmd;
   logic [3:0]  tx_codec;
   logic        ring_full;
   logic        ring_empty;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] mem [256];
   logic [31:0] rx_cmd [64];
   logic [3:0]  rx_cad [64];
   int          rx_n = 0;

   always #10 clk = ~clk;

   cmd_ring_engine u0 (
      .clk (clk), .rst_n (rst_n), .low_power (low_power),
      .reg_wr_en (reg_wr_en), .reg_wr_sel (reg_wr_sel), .reg_wr_data (reg_wr_data),
      .reg_rd_sel (reg_rd_sel), .reg_rd_data (reg_rd_data),
      .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
      .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
      .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_cmd (tx_cmd), .tx_codec (tx_codec),
      .ring_full (ring_full), .ring_empty (ring_empty)
   );

   // memory model: one-cycle read latency
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd_valid <= 1'b0;
         mem_rd_data  <= '0;
      end else begin
         mem_rd_valid <= mem_rd_en && !mem_rd_valid;
         mem_rd_data  <= mem[mem_rd_addr];
      end
   end

   // log of accepted commands
   always @(posedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (rx_n < 64) begin
            rx_cmd[rx_n] = tx_cmd;
            rx_cad[rx_n] = tx_codec;
         end
         rx_n = rx_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] data);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_sel  = sel;
      reg_wr_data = data;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] v);
      @(negedge clk);
      reg_rd_sel = sel;
      #1 v = reg_rd_data;
   endtask

   task automatic wait_rp(input logic [15:0] target);
      logic [15:0] v;
      for (int i = 0; i < 400; i++) begin
         rd(S_RP, v);
         if (v == target) break;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(S_WP, v); chk("R1 wptr", 32'(v), 32'h0);
      rd(S_RP, v); chk("R1 rptr", 32'(v), 32'h0);
      rd(S_CT, v); chk("R1 run",  32'(v), 32'h0);
      rd(S_SZ, v); chk("R1 size", 32'(v), 32'h2);
      chk("R1 tx_valid", 32'(tx_valid), 32'h0);
   endtask

   task automatic t_rp_reset;
      logic [15:0] v;
      wr(S_RP, 16'h8000);
      rd(S_RP, v); chk("R3 reset bit reflected", 32'(v), 32'h8000);
      wr(S_CT, 16'h0001);
      wr(S_WP, 16'h0002);
      idle(10);
      chk("R3 no fetch while reset bit set", 32'(rx_n), 32'h0);
      wr(S_RP, 16'h0000);
      rd(S_RP, v); chk("R3 pointer reads zero", 32'(v), 32'h0);
      wait_rp(16'h0002);
      chk("R4 two sent", 32'(rx_n), 32'h2);
      chk("R4 first slot", rx_cmd[0], mem[1]);
      chk("R4 second slot", rx_cmd[1], mem[2]);
      chk("R5 codec field", 32'(rx_cad[1]), 32'h2);
      wr(S_RP, 16'h0005);
      rd(S_RP, v); chk("R3 plain write ignored", 32'(v), 32'h2);
   endtask

   task automatic t_backpressure;
      logic [15:0] v;
      logic [31:0] held;
      tx_ready = 1'b0;
      wr(S_WP, 16'h0003);
      idle(6);
      chk("R4 offered", 32'(tx_valid), 32'h1);
      chk("R4 word", tx_cmd, mem[3]);
      chk("R5 codec", 32'(tx_codec), 32'h3);
      held = tx_cmd;
      rd(S_RP, v); chk("R4 rptr waits for handshake", 32'(v), 32'h2);
      idle(3);
      chk("R5 held under backpressure", tx_cmd, held);
      tx_ready = 1'b1;
      rd(S_RP, v); chk("R4 rptr after handshake", 32'(v), 32'h3);
   endtask

   task automatic t_stop;
      logic [15:0] v;
      int base;
      tx_ready = 1'b0;
      wr(S_WP, 16'h0004);
      idle(6);
      chk("R6 in flight", 32'(tx_valid), 32'h1);
      wr(S_CT, 16'h0000);
      rd(S_CT, v); chk("R6 run still reads 1", 32'(v), 32'h1);
      tx_ready = 1'b1;
      idle(2);
      rd(S_CT, v); chk("R6 run reads 0 after drain", 32'(v), 32'h0);
      rd(S_RP, v); chk("R6 in-flight entry done", 32'(v), 32'h4);
      base = rx_n;
      wr(S_WP, 16'h0009);
      idle(20);
      rd(S_RP, v); chk("R6 no fetch when stopped", 32'(v), 32'h4);
      chk("R6 nothing sent", 32'(rx_n), 32'(base));
   endtask

   task automatic t_full;
      wr(S_WP, 16'h0003);
      #1 chk("R7 full", 32'(ring_full), 32'h1);
      chk("R7 not empty", 32'(ring_empty), 32'h0);
      wr(S_WP, 16'h0004);
      #1 chk("R7 empty", 32'(ring_empty), 32'h1);
      chk("R7 not full", 32'(ring_full), 32'h0);
      wr(S_WP, 16'h0005);
      #1 chk("R7 neither", 32'({ring_full, ring_empty}), 32'h0);
   endtask

   task automatic t_size16;
      logic [15:0] v;
      int base;
      wr(S_RP, 16'h8000);
      wr(S_RP, 16'h0000);
      wr(S_SZ, 16'h0001);
      rd(S_SZ, v); chk("R2 size code", 32'(v), 32'h1);
      wr(S_WP, 16'h001F);
      rd(S_WP, v); chk("R2 wptr masked", 32'(v), 32'h000F);
      wr(S_CT, 16'h0001);
      wait_rp(16'h000F);
      chk("R2 last slot", rx_cmd[rx_n-1], mem[15]);
      base = rx_n;
      wr(S_WP, 16'h0002);
      wait_rp(16'h0002);
      chk("R2 wrap count", 32'(rx_n - base), 32'h3);
      chk("R2 wrap to slot 0", rx_cmd[base], mem[0]);
      chk("R2 slot 2 after wrap", rx_cmd[base+2], mem[2]);
      wr(S_CT, 16'h0000);
      wr(S_WP, 16'h0001);
      #1 chk("R7 full at 16 entries", 32'(ring_full), 32'h1);
   endtask

   task automatic t_lowpower;
      logic [15:0] v;
      low_power = 1'b1;
      rd(S_WP, v); chk("R8 wptr all ones", 32'(v), 32'hFFFF);
      rd(S_RP, v); chk("R8 rptr normal", 32'(v), 32'h2);
      rd(S_SZ, v); chk("R8 size normal", 32'(v), 32'h1);
      low_power = 1'b0;
      rd(S_WP, v); chk("R8 wptr back", 32'(v), 32'h1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = {4'(i), 20'h5A5A5, 8'(i)};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rp_reset();
      t_backpressure();
      t_stop();
      t_full();
      t_size16();
      t_lowpower();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule